// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a bank of lock flags that two independent ports (called left and right) share, so that software on each side can claim and hand back shared resources without a memory race. A port touches the bank when its memory chip enable is high and its active-low semaphore select is low. The low address bits pick one flag, and bit 0 of the write data carries the command. A 0 asks for the token and a 1 gives it up.

A request that arrives while the other port holds the token is not lost. It is kept as a waiting claim and turns into ownership in the cycle the holder gives the token back. Each port reads the flag from its own side. The value 0 means "this port holds the token". The value is copied onto every data bit so that software can test it with any bit mask. Writes update the flag state on the rising clock edge. Reads are combinational and show the state held before that edge.

Top module: `dual_sema_bank`

## Requirements
- R1: After reset, every flag is free and has no waiting claim, so a read from either port of any flag returns all ones.
- R2: A port reaches the bank only when its memory chip enable is 1 and its semaphore select is 0. Any other combination ignores writes and drives read data to all zeros.
- R3: Address bits [2:0] choose one of eight independent flags, and higher address bits are ignored. A write to one flag leaves all the others unchanged.
- R4: The write strobe is 1 for a write and 0 for a read. Only write data bit 0 matters: 0 requests the token and 1 releases it. All other data bits are ignored.
- R5: A request to a free flag takes the token at the next clock edge. From then on the holder reads all zeros and the other port reads all ones.
- R6: A request from the non-holding port leaves the visible state unchanged. When the holder later releases, the token passes directly to the waiting port.
- R7: A release by the holder with no waiting claim makes the flag free again, and both ports read all ones.
- R8: A request written by the holder changes nothing, including while the other port has a claim waiting.
- R9: If both ports request a free flag at the same edge, the left port takes the token and the right request becomes a waiting claim.
- R10: A release written by a port that does not hold the token cancels that port's own waiting claim, so a later release by the holder frees the flag.
- R11: A read returns the port's view of the selected flag on all 18 data bits, and that view always agrees with the history of requests and releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_mem_ce | input | 1 | Left memory chip enable; must be 1 for semaphore access |
| lt_sem_sel_n | input | 1 | Left semaphore select, active low |
| lt_wr | input | 1 | Left write strobe (1 write, 0 read) |
| lt_addr | input | 17 | Left address; bits [2:0] pick the flag |
| lt_wdata | input | 18 | Left write data; bit 0 is the command |
| lt_rdata | output | 18 | Left read data, the left view copied on every bit |
| rt_mem_ce | input | 1 | Right memory chip enable; must be 1 for semaphore access |
| rt_sem_sel_n | input | 1 | Right semaphore select, active low |
| rt_wr | input | 1 | Right write strobe (1 write, 0 read) |
| rt_addr | input | 17 | Right address; bits [2:0] pick the flag |
| rt_wdata | input | 18 | Right write data; bit 0 is the command |
| rt_rdata | output | 18 | Right read data, the right view copied on every bit |

## Verification
The properties assume that each port issues at most one command per cycle, and that this command targets a single flag. They also assume that reset is held low across at least one rising edge before the ports are used. The stimulus meets these assumptions because it gives each port exactly one operation per cycle: idle, read, request, release, or a write with access disabled. The flag index and the unused address and data bits are drawn at random. The two ports are free to collide on the same flag, so ties, waiting claims and cancellations occur many times during the random phase.

// File: rtl/sema_pkg.sv
package sema_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;
endpackage

// File: rtl/sema_cell.sv
module sema_cell
   import sema_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic l_take,
   input  logic l_give,
   input  logic r_take,
   input  logic r_give,
   output logic l_view,
   output logic r_view
);
   owner_e owner_q, owner_d;
   logic   wait_q, wait_d;   // the non-holding side has a claim waiting
   logic   wait_l, wait_r;

   always_comb begin
      owner_d = owner_q;
      wait_d  = wait_q;
      wait_l  = 1'b0;
      wait_r  = 1'b0;
      case (owner_q)
         OWN_NONE: begin
            if (l_take) begin
               owner_d = OWN_LEFT;
               wait_d  = r_take;
            end else if (r_take) begin
               owner_d = OWN_RIGHT;
               wait_d  = 1'b0;
            end
         end
         OWN_LEFT: begin
            wait_r = (wait_q | r_take) & ~r_give;
            if (l_give) begin
               owner_d = wait_r ? OWN_RIGHT : OWN_NONE;
               wait_d  = 1'b0;
            end else begin
               wait_d  = wait_r;
            end
         end
         OWN_RIGHT: begin
            wait_l = (wait_q | l_take) & ~l_give;
            if (r_give) begin
               owner_d = wait_l ? OWN_LEFT : OWN_NONE;
               wait_d  = 1'b0;
            end else begin
               wait_d  = wait_l;
            end
         end
         default: begin
            owner_d = OWN_NONE;
            wait_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_NONE;
         wait_q  <= 1'b0;
      end else begin
         owner_q <= owner_d;
         wait_q  <= wait_d;
      end
   end

   assign l_view = (owner_q != OWN_LEFT);
   assign r_view = (owner_q != OWN_RIGHT);

   // R7
   free_on_give_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_LEFT && l_give && !wait_q && !r_take) |=> (l_view && r_view));

   // R6
   grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_LEFT && wait_q && l_give && !r_give) |=> (!r_view && l_view));

   // R8
   hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_view && !l_give) |=> !l_view);

   // R8
   hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_view && !r_give) |=> !r_view);

   // R9
   tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_view && r_view && l_take && r_take) |=> (!l_view && wait_q));
endmodule

// File: rtl/sema_port.sv
module sema_port #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 17,
   parameter int DATA_W  = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mem_ce,
   input  logic               sel_n,
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SEM-1:0] views,
   output logic [NUM_SEM-1:0] take,
   output logic [NUM_SEM-1:0] give,
   output logic [DATA_W-1:0]  rdata
);
   localparam int SEL_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

   logic             access;
   logic [SEL_W-1:0] idx;

   assign access = mem_ce & ~sel_n;
   assign idx    = addr[SEL_W-1:0];

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
      logic hit;
      assign hit     = access & wr & (idx == SEL_W'(i));
      assign take[i] = hit & ~wdata[0];
      assign give[i] = hit &  wdata[0];
   end

   assign rdata = (access && !wr) ? {DATA_W{views[idx]}} : '0;

   // R3
   one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take | give));
endmodule

// File: rtl/dual_sema_bank.sv
module dual_sema_bank #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 17,
   parameter int DATA_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lt_mem_ce,
   input  logic              lt_sem_sel_n,
   input  logic              lt_wr,
   input  logic [ADDR_W-1:0] lt_addr,
   input  logic [DATA_W-1:0] lt_wdata,
   output logic [DATA_W-1:0] lt_rdata,
   input  logic              rt_mem_ce,
   input  logic              rt_sem_sel_n,
   input  logic              rt_wr,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic [DATA_W-1:0] rt_wdata,
   output logic [DATA_W-1:0] rt_rdata
);
   localparam int SEL_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

   if (NUM_SEM < 2 || (1 << SEL_W) != NUM_SEM) begin : g_bad_count
      $error("NUM_SEM must be a power of two of at least 2");
   end
   if (ADDR_W < SEL_W) begin : g_bad_addr
      $error("ADDR_W too narrow for NUM_SEM");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [NUM_SEM-1:0] l_take, l_give, r_take, r_give;
   logic [NUM_SEM-1:0] l_view, r_view;

   sema_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_left (
      .clk(clk), .rst_n(rst_n),
      .mem_ce(lt_mem_ce), .sel_n(lt_sem_sel_n), .wr(lt_wr),
      .addr(lt_addr), .wdata(lt_wdata), .views(l_view),
      .take(l_take), .give(l_give), .rdata(lt_rdata)
   );

   sema_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_right (
      .clk(clk), .rst_n(rst_n),
      .mem_ce(rt_mem_ce), .sel_n(rt_sem_sel_n), .wr(rt_wr),
      .addr(rt_addr), .wdata(rt_wdata), .views(r_view),
      .take(r_take), .give(r_give), .rdata(rt_rdata)
   );

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
      sema_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .l_take(l_take[i]), .l_give(l_give[i]),
         .r_take(r_take[i]), .r_give(r_give[i]),
         .l_view(l_view[i]), .r_view(r_view[i])
      );
   end
endmodule

// File: tb/dual_sema_bank_test.sv
module dual_sema_bank_test;
   localparam int N  = 8;
   localparam int AW = 17;
   localparam int DW = 18;

   typedef enum int {K_IDLE, K_RD, K_TAKE, K_GIVE, K_OFF} kind_e;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lt_mem_ce, lt_sem_sel_n, lt_wr, rt_mem_ce, rt_sem_sel_n, rt_wr;
   logic [AW-1:0] lt_addr, rt_addr;
   logic [DW-1:0] lt_wdata, rt_wdata, lt_rdata, rt_rdata;

   int errs = 0;
   int checks = 0;
   bit done = 0;
   int m_own [N];   // 0 free, 1 left, 2 right
   bit m_wait [N];

   always #4 clk = ~clk;

   dual_sema_bank uut (
      .clk(clk), .rst_n(rst_n),
      .lt_mem_ce(lt_mem_ce), .lt_sem_sel_n(lt_sem_sel_n), .lt_wr(lt_wr),
      .lt_addr(lt_addr), .lt_wdata(lt_wdata), .lt_rdata(lt_rdata),
      .rt_mem_ce(rt_mem_ce), .rt_sem_sel_n(rt_sem_sel_n), .rt_wr(rt_wr),
      .rt_addr(rt_addr), .rt_wdata(rt_wdata), .rt_rdata(rt_rdata)
   );

   function automatic bit view(int side, int i);
      return !(m_own[i] == side + 1);
   endfunction

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_side(int side, kind_e k, int idx);
      logic ce, sn, w;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'($urandom);
      a[2:0] = 3'(idx);
      d = DW'($urandom);
      ce = 1'b1; sn = 1'b0; w = 1'b0;
      case (k)
         K_IDLE: begin ce = 1'($urandom); sn = 1'b1; end
         K_RD:   w = 1'b0;
         K_TAKE: begin w = 1'b1; d[0] = 1'b0; end
         K_GIVE: begin w = 1'b1; d[0] = 1'b1; end
         K_OFF: begin
            w = 1'b1;
            if ($urandom % 2 == 0) ce = 1'b0; else sn = 1'b1;
         end
         default: ;
      endcase
      if (side == 0) begin
         lt_mem_ce = ce; lt_sem_sel_n = sn; lt_wr = w; lt_addr = a; lt_wdata = d;
      end else begin
         rt_mem_ce = ce; rt_sem_sel_n = sn; rt_wr = w; rt_addr = a; rt_wdata = d;
      end
   endtask

   // apply one edge of commands to the reference model
   task automatic model_step(kind_e kl, int il, kind_e kr, int ir);
      for (int i = 0; i < N; i++) begin
         bit lt, lg, rt, rg, oreq, orel, hrel, w;
         int o;
         lt = (kl == K_TAKE) && (il == i);
         lg = (kl == K_GIVE) && (il == i);
         rt = (kr == K_TAKE) && (ir == i);
         rg = (kr == K_GIVE) && (ir == i);
         if (m_own[i] == 0) begin
            if (lt) begin m_own[i] = 1; m_wait[i] = rt; end
            else if (rt) begin m_own[i] = 2; m_wait[i] = 0; end
         end else begin
            o    = (m_own[i] == 1) ? 2 : 1;
            oreq = (o == 2) ? rt : lt;
            orel = (o == 2) ? rg : lg;
            hrel = (o == 2) ? lg : rg;
            w    = (m_wait[i] | oreq) & !orel;
            if (hrel) begin m_own[i] = w ? o : 0; m_wait[i] = 0; end
            else m_wait[i] = w;
         end
      end
   endtask

   task automatic cyc(kind_e kl, int il, kind_e kr, int ir, string tag);
      @(negedge clk);
      set_side(0, kl, il);
      set_side(1, kr, ir);
      #1;
      chk({tag, " left"},  lt_rdata, (kl == K_RD) ? {DW{view(0, il)}} : '0);
      chk({tag, " right"}, rt_rdata, (kr == K_RD) ? {DW{view(1, ir)}} : '0);
      @(posedge clk);
      model_step(kl, il, kr, ir);
   endtask

   task automatic look(int idx, bit el, bit er, string tag);
      @(negedge clk);
      set_side(0, K_RD, idx);
      set_side(1, K_RD, idx);
      #1;
      chk({tag, " left view"},  lt_rdata, {DW{el}});
      chk({tag, " right view"}, rt_rdata, {DW{er}});
   endtask

   function automatic kind_e pick();
      int r = $urandom % 10;
      if (r < 2) return K_IDLE;
      if (r < 5) return K_RD;
      if (r < 7) return K_TAKE;
      if (r < 9) return K_GIVE;
      return K_OFF;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin m_own[i] = 0; m_wait[i] = 0; end
      set_side(0, K_IDLE, 0);
      set_side(1, K_IDLE, 0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < N; i++) look(i, 1'b1, 1'b1, "R1");

      // R5 take a free flag; R3 neighbour untouched; R4 junk data bits
      cyc(K_TAKE, 3, K_IDLE, 0, "R5");
      look(3, 1'b0, 1'b1, "R5");
      look(2, 1'b1, 1'b1, "R3");
      look(4, 1'b1, 1'b1, "R4");
      // R8 holder requests again
      cyc(K_TAKE, 3, K_IDLE, 0, "R8");
      look(3, 1'b0, 1'b1, "R8");
      // R6 denied request stays invisible
      cyc(K_IDLE, 0, K_TAKE, 3, "R6");
      look(3, 1'b0, 1'b1, "R6");
      cyc(K_TAKE, 3, K_IDLE, 0, "R8");
      look(3, 1'b0, 1'b1, "R8 with claim");
      cyc(K_GIVE, 3, K_IDLE, 0, "R6");
      look(3, 1'b1, 1'b0, "R6 grant");
      // R7 release without claim
      cyc(K_IDLE, 0, K_GIVE, 3, "R7");
      look(3, 1'b1, 1'b1, "R7");
      // R9 tie
      cyc(K_TAKE, 5, K_TAKE, 5, "R9");
      look(5, 1'b0, 1'b1, "R9");
      cyc(K_GIVE, 5, K_IDLE, 0, "R9");
      look(5, 1'b1, 1'b0, "R9 grant");
      cyc(K_IDLE, 0, K_GIVE, 5, "R7");
      look(5, 1'b1, 1'b1, "R7 after tie");
      // R10 cancel own claim
      cyc(K_IDLE, 0, K_TAKE, 6, "R10");
      cyc(K_TAKE, 6, K_IDLE, 0, "R10");
      cyc(K_GIVE, 6, K_IDLE, 0, "R10");
      look(6, 1'b1, 1'b0, "R10");
      cyc(K_IDLE, 0, K_GIVE, 6, "R10");
      look(6, 1'b1, 1'b1, "R10 freed");
      // R2 disabled access ignored
      cyc(K_OFF, 1, K_OFF, 1, "R2");
      @(negedge clk);
      lt_mem_ce = 1'b1; lt_sem_sel_n = 1'b0; lt_wr = 1'b1; lt_addr = '0; lt_wdata = '0;
      rt_mem_ce = 1'b0; rt_sem_sel_n = 1'b0; rt_wr = 1'b1; rt_addr = '0; rt_wdata = '0;
      lt_mem_ce = 1'b0;
      @(posedge clk);
      look(0, 1'b1, 1'b1, "R2");

      // R11 random mix against the model
      for (int n = 0; n < 3000; n++) begin
         kind_e kl, kr;
         kl = pick();
         kr = pick();
         cyc(kl, int'($urandom % N), kr, int'($urandom % N), "R11");
      end
      for (int i = 0; i < N; i++) look(i, view(0, i), view(1, i), "R11 sweep");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule